// File: doc/BRIEF.md
# Damped Resonator Tone Oscillator

This block makes audio-rate tone samples by stepping a second-order resonator instead of walking a phase accumulator through a table. It holds two signed state words, a position and a velocity. On every sample strobe it derives an acceleration from the position, applies several loss terms, and injects energy while the note gate is held. It then moves the velocity and, using that new velocity, the position. The sample is the top slice of the position.

Because the amplitude comes from a balance between injected energy and losses, a note swells in when the gate rises, holds a steady level, and dies away once the gate falls. The pitch wanders slightly while the level is changing. A built-in pseudo-random noise source is added to the drive, so a resonator at rest starts swinging by itself. The frequency word may be changed at any time. The state is never cleared or reloaded, so the waveform stays continuous across a pitch change.

Coefficients are unsigned Q0.16 fractions. The state words are signed integers whose full scale is ±2^23.

Top module: `reso_tone_osc`

## Requirements
- R1: While reset is low, position and velocity are zero, `sample_out` is 0 and `sample_vld` is 0. The noise register is loaded with 16'hACE1.
- R2: `sample_vld` is 1 in exactly the cycle after a cycle with `sample_stb` high, and 0 otherwise. Without a strobe the state and `sample_out` do not change.
- R3: On a strobe the velocity is updated first: v' = v − ((w·p)>>>16) − losses + drive + noise. Then the position is updated from the new velocity: p' = p + ((w·v')>>>16). Here w is `freq_word`, and >>> is a flooring arithmetic shift applied to each term separately. `sample_out` is p[23:8].
- R4: The position loss term ((p·`pos_loss`)>>>16) is subtracted from the velocity on every update.
- R5: The velocity loss term ((v·`vel_loss`)>>>16) is subtracted from the velocity on every update.
- R6: The nonlinear loss term ((((v·|v|)>>>23)·`nl_loss`)>>>16) is subtracted from the velocity on every update.
- R7: While `gate` is 1, `drive_lvl` is added to the velocity when v ≥ 0 and subtracted from it when v < 0.
- R8: The noise register is a 16-bit shift register. On each strobe it shifts left, and bit 0 receives bit15 ^ bit13 ^ bit12 ^ bit10. It advances on every strobe regardless of `gate`, and it is never zero. While `gate` is 1 the term ((n·`noise_gain`)>>>16) is added to the velocity. Here n is the register value before the shift, read as a signed number.
- R9: While `gate` is 0, neither drive nor noise is added. A resonator at rest stays at rest, and a swinging one decays through its losses alone.
- R10: The new velocity and the new position each clamp to the range [−2^23, 2^23−1] instead of wrapping.
- R11: A change of `freq_word` does not reset or reload the state. The next update starts from the stored position and velocity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_stb | input | 1 | One-cycle request for the next sample |
| freq_word | input | 16 | Resonance coefficient w, Q0.16 |
| gate | input | 1 | Note held; enables drive and noise |
| drive_lvl | input | 16 | Energy added per update in the direction of the velocity |
| noise_gain | input | 16 | Scale of the noise injection, Q0.16 |
| pos_loss | input | 16 | Position-proportional loss, Q0.16 |
| vel_loss | input | 16 | Velocity-proportional loss, Q0.16 |
| nl_loss | input | 16 | Nonlinear (velocity-squared) loss, Q0.16 |
| sample_out | output | 16 | Signed tone sample (top of position) |
| sample_vld | output | 1 | High one cycle after each strobe |

## Verification
Two functions can meet in one cycle: a gate release that coincides with a strobe, and the advance of the noise register. The update on that edge must leave out the noise term while the register still shifts. The bench lowers `gate` just before a strobe while `noise_gain` and `drive_lvl` remain at full scale. Every later sample is compared exactly against an independent model of the resonator and of the shift-register sequence, so either a stray injection or a skipped shift causes a mismatch. Clamping can also coincide with drive injection. That case is driven with full-scale drive and no losses until the position reaches its rail.

// File: rtl/reso_pkg.sv
package reso_pkg;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // Fibonacci shift left, taps 16/14/13/11 (bits 15,13,12,10)
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/reso_lfsr.sv
module reso_lfsr
  import reso_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic [LFSR_W-1:0] state_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= LFSR_SEED;
    else if (adv_i) state_o <= lfsr_next(state_o);
  end

  // R8: a maximal-length register never falls into the all-zero lock state
  assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != '0);

  // R8: the register moves only on a strobe
  assert_lfsr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(state_o));

endmodule

// File: rtl/reso_step.sv
module reso_step #(
  parameter int STATE_W = 24,
  parameter int COEF_W  = 16,
  parameter int NOISE_W = 16
) (
  input  logic signed [STATE_W-1:0] pos_i,
  input  logic signed [STATE_W-1:0] vel_i,
  input  logic        [COEF_W-1:0]  freq_i,
  input  logic        [COEF_W-1:0]  kpos_i,
  input  logic        [COEF_W-1:0]  kvel_i,
  input  logic        [COEF_W-1:0]  knl_i,
  input  logic        [COEF_W-1:0]  drive_i,
  input  logic        [COEF_W-1:0]  ngain_i,
  input  logic        [NOISE_W-1:0] noise_i,
  input  logic                      gate_i,
  output logic signed [STATE_W-1:0] pos_o,
  output logic signed [STATE_W-1:0] vel_o,
  output logic                      vel_clip_o,
  output logic                      pos_clip_hi_o,
  output logic                      pos_clip_lo_o
);

  localparam int XW  = STATE_W + 1;          // state with one guard bit
  localparam int PW  = XW + COEF_W + 1;      // coefficient product
  localparam int AW  = STATE_W + 4;          // velocity/position sum
  localparam int SQW = 2 * XW;               // v*|v| product
  localparam logic signed [AW-1:0] MAX_A = (AW'(1) <<< (STATE_W-1)) - AW'(1);
  localparam logic signed [AW-1:0] MIN_A = ~MAX_A;

  // Multiply by an unsigned Q0.16 coefficient, floor the fraction away
  function automatic logic signed [AW-1:0] scale(input logic signed [XW-1:0] x,
                                                 input logic [COEF_W-1:0] k);
    logic signed [PW-1:0] prod;
    prod = PW'(x) * PW'($signed({1'b0, k}));
    return AW'(prod >>> COEF_W);
  endfunction

  function automatic logic signed [XW-1:0] widen(input logic signed [STATE_W-1:0] a);
    return {a[STATE_W-1], a};
  endfunction

  function automatic logic signed [STATE_W-1:0] clamp(input logic signed [AW-1:0] x);
    if (x > MAX_A) return {1'b0, {(STATE_W-1){1'b1}}};
    else if (x < MIN_A) return {1'b1, {(STATE_W-1){1'b0}}};
    else return x[STATE_W-1:0];
  endfunction

  logic signed [XW-1:0]  px, vx, vmag, vsq, nx;
  logic signed [SQW-1:0] vsq_full;
  logic signed [AW-1:0]  spring, ploss, vloss, nloss, drv, noi, vsum, psum;

  always_comb begin
    px       = widen(pos_i);
    vx       = widen(vel_i);
    vmag     = vel_i[STATE_W-1] ? -vx : vx;
    vsq_full = SQW'(vx) * SQW'(vmag);
    vsq      = XW'(vsq_full >>> (STATE_W-1));
    nx       = {{(XW-NOISE_W){noise_i[NOISE_W-1]}}, noise_i};

    spring = scale(px, freq_i);
    ploss  = scale(px, kpos_i);   // R4
    vloss  = scale(vx, kvel_i);   // R5
    nloss  = scale(vsq, knl_i);   // R6

    // R7 / R9: drive follows velocity sign, only while gated
    drv = '0;
    noi = '0;
    if (gate_i) begin
      drv = vel_i[STATE_W-1] ? -AW'($signed({1'b0, drive_i}))
                             :  AW'($signed({1'b0, drive_i}));
      noi = scale(nx, ngain_i);   // R8
    end

    // R3: velocity first, then position from the new velocity
    vsum  = AW'(vx) - spring - ploss - vloss - nloss + drv + noi;
    vel_o = clamp(vsum);
    psum  = AW'(px) + scale(widen(vel_o), freq_i);
    pos_o = clamp(psum);

    vel_clip_o    = (vsum > MAX_A) || (vsum < MIN_A);
    pos_clip_hi_o = psum > MAX_A;
    pos_clip_lo_o = psum < MIN_A;
  end

endmodule

// File: rtl/reso_tone_osc.sv
module reso_tone_osc
  import reso_pkg::*;
#(
  parameter int STATE_W = 24,
  parameter int OUT_W   = 16,
  parameter int COEF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic [COEF_W-1:0] freq_word,
  input  logic              gate,
  input  logic [COEF_W-1:0] drive_lvl,
  input  logic [COEF_W-1:0] noise_gain,
  input  logic [COEF_W-1:0] pos_loss,
  input  logic [COEF_W-1:0] vel_loss,
  input  logic [COEF_W-1:0] nl_loss,
  output logic [OUT_W-1:0]  sample_out,
  output logic              sample_vld
);

  localparam logic signed [STATE_W-1:0] POS_MAX = {1'b0, {(STATE_W-1){1'b1}}};
  localparam logic signed [STATE_W-1:0] POS_MIN = {1'b1, {(STATE_W-1){1'b0}}};

  logic signed [STATE_W-1:0] pos_q, vel_q, pos_n, vel_n;
  logic [LFSR_W-1:0]         noise_q;
  logic                      vld_q;
  // internal events brought out for the checks below
  logic                      vel_clip_ev, pos_clip_hi_ev, pos_clip_lo_ev;

  reso_lfsr u_noise (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (sample_stb),
    .state_o (noise_q)
  );

  reso_step #(
    .STATE_W (STATE_W),
    .COEF_W  (COEF_W),
    .NOISE_W (LFSR_W)
  ) u_step (
    .pos_i         (pos_q),
    .vel_i         (vel_q),
    .freq_i        (freq_word),
    .kpos_i        (pos_loss),
    .kvel_i        (vel_loss),
    .knl_i         (nl_loss),
    .drive_i       (drive_lvl),
    .ngain_i       (noise_gain),
    .noise_i       (noise_q),
    .gate_i        (gate),
    .pos_o         (pos_n),
    .vel_o         (vel_n),
    .vel_clip_o    (vel_clip_ev),
    .pos_clip_hi_o (pos_clip_hi_ev),
    .pos_clip_lo_o (pos_clip_lo_ev)
  );

  // R1 / R2 / R11: state moves only on a strobe and is never reloaded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      vel_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= sample_stb;
      if (sample_stb) begin
        pos_q <= pos_n;
        vel_q <= vel_n;
      end
    end
  end

  assign sample_out = pos_q[STATE_W-1 -: OUT_W];
  assign sample_vld = vld_q;

  assert_vld_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> sample_vld);

  assert_vld_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> !sample_vld);

  assert_hold_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> ($stable(pos_q) && $stable(vel_q)));

  assert_rest_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !gate && pos_q == '0 && vel_q == '0) |=> (pos_q == '0 && vel_q == '0));

  assert_clip_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && pos_clip_hi_ev) |=> pos_q == POS_MAX);

  assert_clip_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && pos_clip_lo_ev) |=> pos_q == POS_MIN);

  assert_vel_clip_rail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && vel_clip_ev) |=> (vel_q == POS_MAX || vel_q == POS_MIN));

endmodule

// File: tb/reso_tone_osc_tb.sv
module reso_tone_osc_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_stb = 1'b0;
  logic [15:0] freq_word = '0;
  logic        gate = 1'b0;
  logic [15:0] drive_lvl = '0;
  logic [15:0] noise_gain = '0;
  logic [15:0] pos_loss = '0;
  logic [15:0] vel_loss = '0;
  logic [15:0] nl_loss = '0;
  logic [15:0] sample_out;
  logic        sample_vld;

  int n_checks = 0;
  int n_fail = 0;

  // independent model state
  longint      m_p = 0;
  longint      m_v = 0;
  logic [15:0] m_l = 16'hACE1;
  int          peak = 0;
  bit          seen_rail = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  reso_tone_osc u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .freq_word  (freq_word),
    .gate       (gate),
    .drive_lvl  (drive_lvl),
    .noise_gain (noise_gain),
    .pos_loss   (pos_loss),
    .vel_loss   (vel_loss),
    .nl_loss    (nl_loss),
    .sample_out (sample_out),
    .sample_vld (sample_vld)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint rail(input longint x);
    if (x > 64'sd8388607) return 64'sd8388607;
    if (x < -64'sd8388608) return -64'sd8388608;
    return x;
  endfunction

  function automatic longint q16(input longint a, input longint k);
    return (a * k) >>> 16;
  endfunction

  task automatic model_step();
    longint a, vn, mag, nz;
    mag = (m_v < 0) ? -m_v : m_v;
    a = -q16(m_p, longint'(freq_word)) - q16(m_p, longint'(pos_loss))
        - q16(m_v, longint'(vel_loss))
        - q16((m_v * mag) >>> 23, longint'(nl_loss));
    if (gate) begin
      a = a + ((m_v < 0) ? -longint'(drive_lvl) : longint'(drive_lvl));
      nz = longint'($signed(m_l));
      a = a + q16(nz, longint'(noise_gain));
    end
    vn  = rail(m_v + a);
    m_p = rail(m_p + q16(vn, longint'(freq_word)));
    m_v = vn;
    m_l = {m_l[14:0], m_l[15] ^ m_l[13] ^ m_l[12] ^ m_l[10]};
  endtask

  // one strobe; sample and strobe-valid compared one cycle later
  task automatic do_strobe(input string req);
    logic [15:0] exp_s;
    int mag;
    @(negedge clk);
    sample_stb = 1'b1;
    model_step();
    exp_s = 16'(m_p >>> 8);
    @(negedge clk);
    sample_stb = 1'b0;
    check(sample_vld === 1'b1, "R2 valid after strobe", longint'(sample_vld), 1);
    check(sample_out === exp_s, req, longint'($signed(sample_out)), longint'($signed(exp_s)));
    mag = int'($signed(sample_out));
    if (mag < 0) mag = -mag;
    if (mag > peak) peak = mag;
    if (sample_out == 16'h7FFF) seen_rail = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(sample_out === 16'h0000, "R1 reset sample", longint'(sample_out), 0);
    check(sample_vld === 1'b0, "R1 reset valid", longint'(sample_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_rest();
    // gate low with full drive and noise offered: nothing enters
    gate = 1'b0; drive_lvl = 16'hFFFF; noise_gain = 16'hFFFF; freq_word = 16'd20000;
    for (int i = 0; i < 20; i++) do_strobe("R9 rest stays at rest");
    check(sample_out === 16'h0000, "R9 rest final", longint'(sample_out), 0);
  endtask

  task automatic t_valid();
    logic [15:0] held;
    gate = 1'b1; drive_lvl = 16'd4000; noise_gain = 16'd0;
    do_strobe("R2 strobe sample");
    @(negedge clk);
    check(sample_vld === 1'b0, "R2 valid single cycle", longint'(sample_vld), 0);
    held = sample_out;
    drive_lvl = 16'hFFFF; freq_word = 16'd60000;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(sample_out === held, "R2 no change without strobe",
            longint'(sample_out), longint'(held));
      check(sample_vld === 1'b0, "R2 valid low without strobe", longint'(sample_vld), 0);
    end
    drive_lvl = 16'd0; freq_word = 16'd20000;
  endtask

  task automatic t_selfstart();
    gate = 1'b1; drive_lvl = 16'd0; noise_gain = 16'hFFFF;
    vel_loss = 16'd0; pos_loss = 16'd0; nl_loss = 16'd0;
    for (int i = 0; i < 200; i++) do_strobe("R8 noise start R3");
  endtask

  task automatic t_drive();
    gate = 1'b1; drive_lvl = 16'd3000; noise_gain = 16'd0; vel_loss = 16'd300;
    for (int i = 0; i < 300; i++) do_strobe("R7 drive with R5 loss");
  endtask

  task automatic t_losses();
    pos_loss = 16'd500; nl_loss = 16'd3000; noise_gain = 16'd2000;
    for (int i = 0; i < 200; i++) do_strobe("R4 R6 losses");
  endtask

  task automatic t_freq_jump();
    freq_word = 16'd52000;
    for (int i = 0; i < 100; i++) do_strobe("R11 after jump up");
    freq_word = 16'd9000;
    for (int i = 0; i < 100; i++) do_strobe("R11 after jump down");
  endtask

  task automatic t_release();
    int early;
    gate = 1'b0; drive_lvl = 16'hFFFF; noise_gain = 16'hFFFF;
    pos_loss = 16'd0; nl_loss = 16'd0; vel_loss = 16'd1500; freq_word = 16'd20000;
    peak = 0;
    for (int i = 0; i < 64; i++) do_strobe("R9 release");
    early = peak;
    for (int i = 0; i < 200; i++) do_strobe("R9 release");
    peak = 0;
    for (int i = 0; i < 64; i++) do_strobe("R9 release tail");
    check(peak < early || early == 0, "R9 decay", peak, early);
  endtask

  task automatic t_saturate();
    gate = 1'b1; drive_lvl = 16'hFFFF; noise_gain = 16'd0;
    vel_loss = 16'd0; pos_loss = 16'd0; nl_loss = 16'd0; freq_word = 16'd32768;
    seen_rail = 1'b0;
    for (int i = 0; i < 1500; i++) do_strobe("R10 clamp");
    check(seen_rail, "R10 rail reached", longint'(seen_rail), 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_rest();
    t_valid();
    t_selfstart();
    t_drive();
    t_losses();
    t_freq_jump();
    t_release();
    t_saturate();
    finish_run();
  end

endmodule